// File: doc/BRIEF.md
# Size-Masked Register File

This block is a 64-bit general register file with two write ports and three read ports. Each result that reaches a write port comes with a chunk size and a SIMD flag. If the SIMD flag is clear, the write port clears every bit above the operation's chunk before it stores the value. The stored word therefore comes out already zero-extended, and no register ever holds stale upper bits from an older, wider value.

Masking happens only on the way in. It is one AND of the result with a mask, and the mask is built from the size code and the SIMD flag. Each write port has its own mask unit. The read ports return stored words exactly as they are. Register 0 always reads as zero. When both write ports name the same register in one cycle, port 0 wins. Bypass networks, execution units, decode and trap handling belong to the surrounding pipeline and are not part of this block.

Top module: `size_masked_regfile`

## Requirements
- R1: A write with size code 3'b000 (byte) and the SIMD flag clear stores data bits 7..0 and zero in bits 63..8.
- R2: A write with size code 3'b001 (half) and the SIMD flag clear stores data bits 15..0 and zero in bits 63..16.
- R3: A write with size code 3'b011 (word) and the SIMD flag clear stores data bits 31..0 and zero in bits 63..32.
- R4: A write with size code 3'b111 (double) stores all 64 data bits.
- R5: A write with the SIMD flag set stores all 64 data bits, whatever the size code.
- R6: A size code other than 3'b000, 3'b001, 3'b011 and 3'b111 stores all 64 data bits.
- R7: A masked write replaces the whole register. No bit of the previous contents survives above the chunk.
- R8: Each of the three read ports independently returns the stored word of its selected register, without modification.
- R9: A write takes effect at the rising clock edge. A read of the same register in the same cycle returns the previous value.
- R10: When both write ports are enabled for the same register in one cycle, the port 0 value is stored.
- R11: Register 0 reads as zero on every read port, and writes to it have no effect.
- R12: While reset (rst_n low) is asserted, all registers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_idx | input | 5 | Write port 0 destination register |
| wr0_data | input | 64 | Write port 0 result |
| wr0_size | input | 3 | Write port 0 chunk size code |
| wr0_simd | input | 1 | Write port 0 SIMD flag (whole-word store) |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_idx | input | 5 | Write port 1 destination register |
| wr1_data | input | 64 | Write port 1 result |
| wr1_size | input | 3 | Write port 1 chunk size code |
| wr1_simd | input | 1 | Write port 1 SIMD flag |
| rd0_idx | input | 5 | Read port 0 register select |
| rd0_data | output | 64 | Read port 0 word |
| rd1_idx | input | 5 | Read port 1 register select |
| rd1_data | output | 64 | Read port 1 word |
| rd2_idx | input | 5 | Read port 2 register select |
| rd2_data | output | 64 | Read port 2 word |

## Verification
Two kinds of overlap can happen in one cycle. Both write ports can target the same register, and a read port can select a register that is being written in that same cycle. The bench forces both cases with directed cycles: both ports aimed at one register with different sizes and data, and reads pointed at the destination while the write is still pending. It then keeps doing so at random, with indices drawn from a small range. The reference model judges each cycle's reads against the state before the edge, and it applies port 1 before port 0 so that port 0's value is the one kept.

// File: rtl/smrf_pkg.sv
package smrf_pkg;

  localparam int unsigned WORD_W = 64;
  localparam int unsigned SIZE_W = 3;

  typedef enum logic [SIZE_W-1:0] {
    CHUNK_BYTE   = 3'b000,
    CHUNK_HALF   = 3'b001,
    CHUNK_WORD   = 3'b011,
    CHUNK_DOUBLE = 3'b111
  } chunk_e;

  // True for the four defined chunk codes.
  function automatic logic chunk_legal(input logic [SIZE_W-1:0] code);
    return (code == CHUNK_BYTE) || (code == CHUNK_HALF) ||
           (code == CHUNK_WORD) || (code == CHUNK_DOUBLE);
  endfunction

  // Keep-mask: each upper field survives if SIMD is set or its size bit is set.
  // Undefined codes fall back to a full-word keep.
  function automatic logic [WORD_W-1:0] keep_mask(input logic [SIZE_W-1:0] code,
                                                  input logic             simd);
    logic [SIZE_W-1:0]  eff;
    logic [WORD_W-1:0]  m;
    eff        = chunk_legal(code) ? code : CHUNK_DOUBLE;
    m          = '1;
    m[63:32]   = {32{simd | eff[2]}};
    m[31:16]   = {16{simd | eff[1]}};
    m[15:8]    = {8{simd | eff[0]}};
    return m;
  endfunction

endpackage

// File: rtl/rf_write_mask.sv
module rf_write_mask
  import smrf_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] idx,
  input  logic [WORD_W-1:0] data,
  input  logic [SIZE_W-1:0] size,
  input  logic              simd,
  output logic              fire,
  output logic [WORD_W-1:0] masked
);

  logic [WORD_W-1:0] mask;

  assign mask   = keep_mask(size, simd);
  assign masked = data & mask;
  assign fire   = en && (idx != '0);

endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import smrf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_WR   = 2,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire [NUM_WR],
  input  logic [ADDR_W-1:0] wr_idx  [NUM_WR],
  input  logic [WORD_W-1:0] wr_data [NUM_WR],
  output logic [WORD_W-1:0] regs    [NUM_REGS]
);

  logic [WORD_W-1:0] mem [NUM_REGS];

  // Highest port first so the lowest-numbered port lands last and wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) mem[r] <= '0;
    end else begin
      for (int p = NUM_WR - 1; p >= 0; p--) begin
        if (wr_fire[p]) mem[wr_idx[p]] <= wr_data[p];
      end
    end
  end

  assign regs = mem;

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import smrf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [WORD_W-1:0] regs [NUM_REGS],
  input  logic [ADDR_W-1:0] idx,
  output logic [WORD_W-1:0] data
);

  assign data = (idx == '0) ? '0 : regs[idx];

endmodule

// File: rtl/size_masked_regfile.sv
module size_masked_regfile
  import smrf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned NUM_WR  = 2,
  localparam int unsigned NUM_RD  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr0_en,
  input  logic [ADDR_W-1:0] wr0_idx,
  input  logic [WORD_W-1:0] wr0_data,
  input  logic [SIZE_W-1:0] wr0_size,
  input  logic              wr0_simd,
  input  logic              wr1_en,
  input  logic [ADDR_W-1:0] wr1_idx,
  input  logic [WORD_W-1:0] wr1_data,
  input  logic [SIZE_W-1:0] wr1_size,
  input  logic              wr1_simd,
  input  logic [ADDR_W-1:0] rd0_idx,
  output logic [WORD_W-1:0] rd0_data,
  input  logic [ADDR_W-1:0] rd1_idx,
  output logic [WORD_W-1:0] rd1_data,
  input  logic [ADDR_W-1:0] rd2_idx,
  output logic [WORD_W-1:0] rd2_data
);

  // Named internal events, visible to the bound checker.
  logic              wr_en_v   [NUM_WR];
  logic [ADDR_W-1:0] wr_idx_v  [NUM_WR];
  logic [WORD_W-1:0] wr_data_v [NUM_WR];
  logic [SIZE_W-1:0] wr_size_v [NUM_WR];
  logic              wr_simd_v [NUM_WR];
  logic              wr_fire   [NUM_WR];
  logic [WORD_W-1:0] wr_masked [NUM_WR];
  logic [ADDR_W-1:0] rd_idx_v  [NUM_RD];
  logic [WORD_W-1:0] rd_data_v [NUM_RD];
  logic [WORD_W-1:0] regs      [NUM_REGS];

  assign wr_en_v[0]   = wr0_en;   assign wr_en_v[1]   = wr1_en;
  assign wr_idx_v[0]  = wr0_idx;  assign wr_idx_v[1]  = wr1_idx;
  assign wr_data_v[0] = wr0_data; assign wr_data_v[1] = wr1_data;
  assign wr_size_v[0] = wr0_size; assign wr_size_v[1] = wr1_size;
  assign wr_simd_v[0] = wr0_simd; assign wr_simd_v[1] = wr1_simd;

  assign rd_idx_v[0] = rd0_idx;
  assign rd_idx_v[1] = rd1_idx;
  assign rd_idx_v[2] = rd2_idx;

  generate
    for (genvar p = 0; p < NUM_WR; p++) begin : g_wr
      rf_write_mask #(.ADDR_W(ADDR_W)) u_mask (
        .en     (wr_en_v[p]),
        .idx    (wr_idx_v[p]),
        .data   (wr_data_v[p]),
        .size   (wr_size_v[p]),
        .simd   (wr_simd_v[p]),
        .fire   (wr_fire[p]),
        .masked (wr_masked[p])
      );
    end
  endgenerate

  rf_bank #(.NUM_REGS(NUM_REGS), .NUM_WR(NUM_WR)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .wr_idx  (wr_idx_v),
    .wr_data (wr_masked),
    .regs    (regs)
  );

  generate
    for (genvar q = 0; q < NUM_RD; q++) begin : g_rd
      rf_read_port #(.NUM_REGS(NUM_REGS)) u_rd (
        .regs (regs),
        .idx  (rd_idx_v[q]),
        .data (rd_data_v[q])
      );
    end
  endgenerate

  assign rd0_data = rd_data_v[0];
  assign rd1_data = rd_data_v[1];
  assign rd2_data = rd_data_v[2];

endmodule

// File: rtl/smrf_checker.sv
module smrf_checker
  import smrf_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] wr0_idx,
  input logic [WORD_W-1:0] wr0_data,
  input logic [SIZE_W-1:0] wr0_size,
  input logic              wr0_simd,
  input logic [ADDR_W-1:0] wr1_idx,
  input logic [WORD_W-1:0] wr1_data,
  input logic [SIZE_W-1:0] wr1_size,
  input logic              wr1_simd,
  input logic              fire0,
  input logic              fire1,
  input logic [WORD_W-1:0] masked0,
  input logic [WORD_W-1:0] masked1,
  input logic [ADDR_W-1:0] rd0_idx,
  input logic [WORD_W-1:0] rd0_data,
  input logic [ADDR_W-1:0] rd1_idx,
  input logic [WORD_W-1:0] rd1_data,
  input logic [ADDR_W-1:0] rd2_idx,
  input logic [WORD_W-1:0] rd2_data
);

  a_r1_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fire0 && !wr0_simd && wr0_size == 3'b000) |->
      (masked0[63:8] == '0 && masked0[7:0] == wr0_data[7:0]));

  a_r2_half_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fire1 && !wr1_simd && wr1_size == 3'b001) |->
      (masked1[63:16] == '0 && masked1[15:0] == wr1_data[15:0]));

  a_r3_word_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fire0 && !wr0_simd && wr0_size == 3'b011) |->
      (masked0[63:32] == '0 && masked0[31:0] == wr0_data[31:0]));

  a_r5_simd_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (fire0 && wr0_simd) |-> (masked0 == wr0_data));

  a_r6_odd_code_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (fire1 && !(wr1_size inside {3'b000, 3'b001, 3'b011})) |-> (masked1 == wr1_data));

  // R9 and R10: port 0's value is what the register holds after the edge.
  a_r10_port0_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fire0) && rd0_idx == $past(wr0_idx)) |->
      (rd0_data == $past(masked0)));

  a_r9_port1_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(fire1) && !($past(fire0) && $past(wr0_idx) == $past(wr1_idx))
     && rd1_idx == $past(wr1_idx)) |-> (rd1_data == $past(masked1)));

  a_r11_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd0_idx == '0) || (rd1_idx == '0) || (rd2_idx == '0)) |->
      (((rd0_idx != '0) || (rd0_data == '0)) && ((rd1_idx != '0) || (rd1_data == '0))
       && ((rd2_idx != '0) || (rd2_data == '0))));

endmodule

bind size_masked_regfile smrf_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr0_idx  (wr0_idx),
  .wr0_data (wr0_data),
  .wr0_size (wr0_size),
  .wr0_simd (wr0_simd),
  .wr1_idx  (wr1_idx),
  .wr1_data (wr1_data),
  .wr1_size (wr1_size),
  .wr1_simd (wr1_simd),
  .fire0    (wr_fire[0]),
  .fire1    (wr_fire[1]),
  .masked0  (wr_masked[0]),
  .masked1  (wr_masked[1]),
  .rd0_idx  (rd0_idx),
  .rd0_data (rd0_data),
  .rd1_idx  (rd1_idx),
  .rd1_data (rd1_data),
  .rd2_idx  (rd2_idx),
  .rd2_data (rd2_data)
);

// File: tb/tb_size_masked_regfile.sv
module tb_size_masked_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr0_en = 0, wr1_en = 0, wr0_simd = 0, wr1_simd = 0;
  logic [4:0]  wr0_idx = 0, wr1_idx = 0, rd0_idx = 0, rd1_idx = 0, rd2_idx = 0;
  logic [63:0] wr0_data = 0, wr1_data = 0;
  logic [2:0]  wr0_size = 0, wr1_size = 0;
  logic [63:0] rd0_data, rd1_data, rd2_data;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [63:0] model [32];

  always #10 clk = ~clk;  // 50 MHz

  size_masked_regfile dut (
    .clk(clk), .rst_n(rst_n),
    .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_data(wr0_data), .wr0_size(wr0_size), .wr0_simd(wr0_simd),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_data(wr1_data), .wr1_size(wr1_size), .wr1_simd(wr1_simd),
    .rd0_idx(rd0_idx), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .rd2_idx(rd2_idx), .rd2_data(rd2_data)
  );

  // Reference: chunk width in bits from the size code, then a low-bit mask.
  function automatic logic [63:0] ref_store(input logic [63:0] d, input logic [2:0] s, input logic simd);
    int width;
    if (simd) return d;
    case (s)
      3'b000:  width = 8;
      3'b001:  width = 16;
      3'b011:  width = 32;
      default: width = 64;
    endcase
    if (width == 64) return d;
    return d & ((64'd1 << width) - 64'd1);
  endfunction

  task automatic check_rd(input int port, input logic [4:0] idx, input logic [63:0] got, input string tag);
    logic [63:0] exp;
    exp = (idx == 0) ? 64'd0 : model[idx];
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s read port %0d reg %0d: got %h expected %h", tag, port, idx, got, exp);
    end
  endtask

  // One clock: drive at negedge, check reads against pre-edge state, update model after edge.
  task automatic cyc(input bit e0, input logic [4:0] i0, input logic [63:0] d0, input logic [2:0] s0, input bit m0,
                     input bit e1, input logic [4:0] i1, input logic [63:0] d1, input logic [2:0] s1, input bit m1,
                     input logic [4:0] a, input logic [4:0] b, input logic [4:0] c, input string tag);
    wr0_en = e0; wr0_idx = i0; wr0_data = d0; wr0_size = s0; wr0_simd = m0;
    wr1_en = e1; wr1_idx = i1; wr1_data = d1; wr1_size = s1; wr1_simd = m1;
    rd0_idx = a; rd1_idx = b; rd2_idx = c;
    #2;
    check_rd(0, a, rd0_data, tag);
    check_rd(1, b, rd1_data, tag);
    check_rd(2, c, rd2_data, tag);
    @(posedge clk);
    if (e1 && i1 != 0) model[i1] = ref_store(d1, s1, m1);
    if (e0 && i0 != 0) model[i0] = ref_store(d0, s0, m0);
    @(negedge clk);
  endtask

  task automatic rd_only(input logic [4:0] a, input logic [4:0] b, input logic [4:0] c, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, a, b, c, tag);
  endtask

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] PAT  = 64'hDEAD_BEEF_C0DE_5A96;

  initial begin
    for (int r = 0; r < 32; r++) model[r] = 64'd0;
    repeat (3) @(negedge clk);
    // R12: registers are clear straight out of reset
    rst_n = 1'b1;
    for (int r = 0; r < 32; r += 3) rd_only(r[4:0], 5'((r + 1) % 32), 5'((r + 2) % 32), "R12");

    // R4: full-width fill of registers 5..10 with ones
    cyc(1, 5, ONES, 3'b111, 0, 1, 6, ONES, 3'b111, 0, 0, 0, 0, "R4");
    cyc(1, 7, ONES, 3'b111, 0, 1, 8, ONES, 3'b111, 0, 5, 6, 0, "R4");
    cyc(1, 9, ONES, 3'b111, 0, 1, 10, ONES, 3'b111, 0, 7, 8, 0, "R4");
    rd_only(9, 10, 5, "R4");

    // R1, R9: byte write to reg5; same-cycle read must see the old ones
    cyc(1, 5, PAT, 3'b000, 0, 0, 0, 0, 0, 0, 5, 5, 5, "R9");
    rd_only(5, 0, 0, "R1");   // R7: upper ones gone
    // R2 on port 1, R3 on port 0
    cyc(1, 7, PAT, 3'b011, 0, 1, 6, PAT, 3'b001, 0, 0, 0, 0, "R2");
    rd_only(6, 7, 5, "R3");
    // R5: SIMD overrides byte size
    cyc(1, 8, PAT, 3'b000, 1, 1, 11, PAT, 3'b001, 1, 8, 0, 0, "R5");
    rd_only(8, 11, 0, "R5");
    // R6: undefined size codes store the whole word
    cyc(1, 9, PAT, 3'b010, 0, 1, 10, PAT, 3'b101, 0, 0, 0, 0, "R6");
    rd_only(9, 10, 9, "R6");
    cyc(1, 12, PAT, 3'b100, 0, 1, 13, PAT, 3'b110, 0, 0, 0, 0, "R6");
    rd_only(12, 13, 0, "R6");
    // R10: both ports to reg14, port 0 must win
    cyc(1, 14, 64'h1111_2222_3333_4444, 3'b111, 0, 1, 14, PAT, 3'b111, 0, 0, 0, 0, "R10");
    rd_only(14, 14, 14, "R10");
    cyc(1, 14, PAT, 3'b000, 0, 1, 14, ONES, 3'b111, 0, 14, 0, 0, "R10");
    rd_only(14, 0, 14, "R10");
    // R11: writes to reg0 are dropped
    cyc(1, 0, ONES, 3'b111, 0, 1, 0, PAT, 3'b111, 1, 0, 0, 0, "R11");
    rd_only(0, 0, 0, "R11");

    // R8: random traffic, small index range to force collisions
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] s0, s1;
      s0 = 3'($urandom);
      s1 = 3'($urandom);
      cyc(bit'($urandom), 5'($urandom % 8), {$urandom, $urandom}, s0, ($urandom % 4) == 0,
          bit'($urandom), 5'($urandom % 8), {$urandom, $urandom}, s1, ($urandom % 4) == 0,
          5'($urandom % 8), 5'($urandom % 8), 5'($urandom % 8), "R8");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule